// File: doc/BRIEF.md
# Hamming ECC Syndrome Checker

This block decides what to do with one 512-byte sub-block after a flash read. It takes two 3-byte Hamming codes. One is the code stored in the spare area. The other is the code computed again while the data was read back. The block classifies the pair as clean, as a correctable single-bit error, or as uncorrectable. For a correctable error it reports the byte offset (0 to 511) and the bit index (0 to 7) that the caller must flip.

Each code is first mapped into a 24-bit ordered vector in which line parities of increasing weight alternate even and odd. The two vectors are XORed, and the decision rests only on how many syndrome bits are set. The error address is read from the odd-parity positions. One pair has a special rule: a stored code of all ones against a computed code of all zeros is accepted as a clean erased block.

The caller drives a one-cycle `start` with both codes present. One cycle later the registered result appears with a `done` strobe. For a 2048-byte page the caller uses the block four times, once for each sub-block.

Top module: `ecc_syndrome_check`

## Requirements
- R1: After reset, `done` is 0, `status` is 2'b00 and `byteOffset` and `bitIndex` are 0.
- R2: When `start` is sampled high at a clock edge, `done` is high for exactly the following cycle. That cycle carries the result for the codes sampled at that edge. If `start` is high on consecutive edges, each edge produces its own result. `done` is low in any cycle that does not follow a sampled `start`.
- R3: Identical stored and computed codes give `status` 2'b00 (clean).
- R4: Code layout in a 24-bit word: byte0 is bits 7:0, byte1 is bits 15:8 and byte2 is bits 23:16.
  - The even parity of weight 2^k sits at byte0 bit k for k<8, and at byte2 bit k-8 for k=8..11.
  - The odd parity of weight 2^k sits at byte1 bit k for k<8, and at byte2 bit k-4 for k=8..11.
  - When exactly 12 bits differ, `status` is 2'b01 (correctable).
  - In that case `byteOffset` is the odd-parity differences of weights 2^11..2^3, MSB first, and `bitIndex` is the odd-parity differences of weights 2^2..2^0.
- R5: When exactly 1 or exactly 11 bits differ, `status` is 2'b10 (uncorrectable).
- R6: Any other nonzero number of differing bits gives `status` 2'b10, except in the R7 case. `status` never takes the value 2'b11.
- R7: A stored code of 24'hFFFFFF with a computed code of 24'h000000 gives `status` 2'b00. The reverse pair is uncorrectable.
- R8: `byteOffset` and `bitIndex` are 0 whenever `status` is not 2'b01.
- R9: While `start` is low, `status`, `byteOffset` and `bitIndex` hold their values, whatever the code inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request: sample both codes this edge |
| storedCode | input | 24 | Code read from the spare area |
| calcCode | input | 24 | Code computed on readback |
| done | output | 1 | Result valid strobe, one cycle after start |
| status | output | 2 | 00 clean, 01 correctable, 10 uncorrectable |
| byteOffset | output | 9 | Byte to correct (0 when not correctable) |
| bitIndex | output | 3 | Bit to correct (0 when not correctable) |

## Verification
Two things can fall in the same cycle: a result being presented, and a new request being sampled. The bench holds `start` high on consecutive edges with different code pairs and checks that each `done` cycle carries its own pair's verdict. It also changes the code inputs while `start` is low and checks that the registered result does not move. A further collision is the erased-block rule, which competes with the popcount rule: the bench checks all-ones against all-zeros, its reverse, and all-ones against codes one bit away from zero.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;

  // number of even/odd parity pairs in one code
  localparam int PAIRS  = 12;
  localparam int CODE_W = 2 * PAIRS;
  localparam int IDX_W  = 3;
  localparam int OFF_W  = PAIRS - IDX_W;
  localparam int CNT_W  = $clog2(CODE_W + 1);

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'b00,
    ST_FIXABLE = 2'b01,
    ST_FATAL   = 2'b10
  } eccStatus_e;

  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

endpackage

// File: rtl/ecc_syn_reorder.sv
// Maps a packed 3-byte code onto the ordered vector:
// bit 2k = even parity of weight 2^k, bit 2k+1 = odd parity of weight 2^k.
module ecc_syn_reorder
  import ecc_syn_pkg::*;
(
  input  logic [CODE_W-1:0] codeIn,
  output logic [CODE_W-1:0] orderedOut
);

  localparam int LOW_PAIRS = 8;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    if (k < LOW_PAIRS) begin : g_low
      assign orderedOut[2*k]     = codeIn[k];
      assign orderedOut[2*k + 1] = codeIn[8 + k];
    end else begin : g_high
      assign orderedOut[2*k]     = codeIn[16 + (k - LOW_PAIRS)];
      assign orderedOut[2*k + 1] = codeIn[20 + (k - LOW_PAIRS)];
    end
  end

endmodule

// File: rtl/ecc_syn_ctrl.sv
module ecc_syn_ctrl
  import ecc_syn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t strb,
  output logic        done
);

  logic doneQ;

  always_comb begin
    strb.load = start;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= start;
  end

  assign done = doneQ;

endmodule

// File: rtl/ecc_syn_datapath.sv
module ecc_syn_datapath
  import ecc_syn_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [CODE_W-1:0] storedCode,
  input  logic [CODE_W-1:0] calcCode,
  output logic [1:0]        status,
  output logic [OFF_W-1:0]  byteOffset,
  output logic [IDX_W-1:0]  bitIndex
);

  logic [CODE_W-1:0] ordStored;
  logic [CODE_W-1:0] ordCalc;
  logic [CODE_W-1:0] synd;
  logic [CNT_W-1:0]  onesCnt;
  logic              isErased;
  eccStatus_e        statusNext;
  logic [OFF_W-1:0]  offRaw;
  logic [IDX_W-1:0]  idxRaw;
  logic [OFF_W-1:0]  offNext;
  logic [IDX_W-1:0]  idxNext;
  eccStatus_e        statusQ;
  logic [OFF_W-1:0]  offQ;
  logic [IDX_W-1:0]  idxQ;

  ecc_syn_reorder u_ordStored (.codeIn(storedCode), .orderedOut(ordStored));
  ecc_syn_reorder u_ordCalc   (.codeIn(calcCode),   .orderedOut(ordCalc));

  assign synd     = ordStored ^ ordCalc;
  assign isErased = (storedCode == {CODE_W{1'b1}}) && (calcCode == '0);

  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < CODE_W; i++) begin
      onesCnt = onesCnt + CNT_W'(synd[i]);
    end
  end

  // error address lives in the odd-parity positions
  for (genvar j = 0; j < IDX_W; j++) begin : g_idx
    assign idxRaw[j] = synd[2*j + 1];
  end
  for (genvar j = 0; j < OFF_W; j++) begin : g_off
    assign offRaw[j] = synd[2*(j + IDX_W) + 1];
  end

  always_comb begin
    if (onesCnt == '0) begin
      statusNext = ST_CLEAN;
    end else if (onesCnt == CNT_W'(PAIRS)) begin
      statusNext = ST_FIXABLE;
    end else if ((onesCnt == CNT_W'(1)) || (onesCnt == CNT_W'(PAIRS - 1))) begin
      statusNext = ST_FATAL;
    end else if (isErased) begin
      statusNext = ST_CLEAN;
    end else begin
      statusNext = ST_FATAL;
    end
    offNext = (statusNext == ST_FIXABLE) ? offRaw : '0;
    idxNext = (statusNext == ST_FIXABLE) ? idxRaw : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= ST_CLEAN;
      offQ    <= '0;
      idxQ    <= '0;
    end else if (strb.load) begin
      statusQ <= statusNext;
      offQ    <= offNext;
      idxQ    <= idxNext;
    end
  end

  assign status     = statusQ;
  assign byteOffset = offQ;
  assign bitIndex   = idxQ;

endmodule

// File: rtl/ecc_syndrome_check.sv
module ecc_syndrome_check
  import ecc_syn_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CODE_W-1:0] storedCode,
  input  logic [CODE_W-1:0] calcCode,
  output logic              done,
  output logic [1:0]        status,
  output logic [OFF_W-1:0]  byteOffset,
  output logic [IDX_W-1:0]  bitIndex
);

  ctrlStrobe_t strb;

  ecc_syn_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  ecc_syn_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .storedCode (storedCode),
    .calcCode   (calcCode),
    .status     (status),
    .byteOffset (byteOffset),
    .bitIndex   (bitIndex)
  );

endmodule

// File: rtl/ecc_syndrome_check_chk.sv
module ecc_syndrome_check_chk
  import ecc_syn_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [CODE_W-1:0] storedCode,
  input logic [CODE_W-1:0] calcCode,
  input logic              done,
  input logic [1:0]        status,
  input logic [OFF_W-1:0]  byteOffset,
  input logic [IDX_W-1:0]  bitIndex
);

  // R2
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  // R2
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

  // R8
  addr_zero_unless_fixable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status != 2'b01) |-> ((byteOffset == '0) && (bitIndex == '0)));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(status) && $stable(byteOffset) && $stable(bitIndex)));

  // R3
  equal_is_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && (storedCode == calcCode)) |=> (status == 2'b00));

  // R5
  single_diff_fatal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && ($countones(storedCode ^ calcCode) == 1)) |=> (status == 2'b10));

  // R7
  erased_is_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && (storedCode == {CODE_W{1'b1}}) && (calcCode == '0)) |=> (status == 2'b00));

  // R6
  status_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    status != 2'b11);

endmodule

bind ecc_syndrome_check ecc_syndrome_check_chk u_chk (.*);

// File: tb/ecc_syndrome_check_bench.sv
`timescale 1ns/1ps
module ecc_syndrome_check_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] storedCode = '0;
  logic [23:0] calcCode = '0;
  logic        done;
  logic [1:0]  status;
  logic [8:0]  byteOffset;
  logic [2:0]  bitIndex;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ecc_syndrome_check u_ecc_syndrome_check (
    .clk(clk), .rstN(rstN), .start(start),
    .storedCode(storedCode), .calcCode(calcCode),
    .done(done), .status(status), .byteOffset(byteOffset), .bitIndex(bitIndex)
  );

  // ordered position -> code bit, from the layout in R4
  function automatic logic [23:0] ordToCode(input logic [23:0] ord);
    logic [23:0] c = '0;
    for (int k = 0; k < 12; k++) begin
      if (k < 8) begin
        c[k]     = ord[2*k];
        c[8 + k] = ord[2*k + 1];
      end else begin
        c[16 + k - 8] = ord[2*k];
        c[20 + k - 8] = ord[2*k + 1];
      end
    end
    return c;
  endfunction

  function automatic logic [23:0] codeToOrd(input logic [23:0] c);
    logic [23:0] o = '0;
    for (int k = 0; k < 12; k++) begin
      if (k < 8) begin
        o[2*k]     = c[k];
        o[2*k + 1] = c[8 + k];
      end else begin
        o[2*k]     = c[16 + k - 8];
        o[2*k + 1] = c[20 + k - 8];
      end
    end
    return o;
  endfunction

  task automatic expectOf(input logic [23:0] s, input logic [23:0] c,
                          output logic [1:0] st, output logic [8:0] off,
                          output logic [2:0] idx);
    int pc;
    logic [23:0] o;
    pc  = $countones(s ^ c);
    o   = codeToOrd(s ^ c);
    off = '0;
    idx = '0;
    if (pc == 0) st = 2'b00;
    else if (pc == 12) begin
      st = 2'b01;
      for (int j = 0; j < 9; j++) off[j] = o[2*(j + 3) + 1];
      for (int j = 0; j < 3; j++) idx[j] = o[2*j + 1];
    end
    else if (pc == 1 || pc == 11) st = 2'b10;
    else if (s == 24'hFFFFFF && c == 24'h0) st = 2'b00;
    else st = 2'b10;
  endtask

  task automatic check(input string req, input logic dn, input logic [1:0] st,
                       input logic [8:0] off, input logic [2:0] idx);
    testCnt++;
    if (done !== dn || status !== st || byteOffset !== off || bitIndex !== idx) begin
      failCnt++;
      $display("FAIL %s: got done=%0d status=%0d off=%0d idx=%0d, expected done=%0d status=%0d off=%0d idx=%0d",
               req, done, status, byteOffset, bitIndex, dn, st, off, idx);
    end
  endtask

  // one request; result checked the cycle after, hold checked one cycle later
  task automatic runOne(input logic [23:0] s, input logic [23:0] c, input string req);
    logic [1:0] st; logic [8:0] off; logic [2:0] idx;
    expectOf(s, c, st, off, idx);
    @(negedge clk);
    storedCode = s; calcCode = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req, 1'b1, st, off, idx);
    storedCode = ~s; calcCode = s ^ 24'h000001;  // ignored while idle
    @(negedge clk);
    check("R9 hold", 1'b0, st, off, idx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [23:0] base, ord, pat;
    logic [1:0] stA, stB; logic [8:0] offA, offB; logic [2:0] idxA, idxB;
    repeat (4) @(negedge clk);
    check("R1 reset", 1'b0, 2'b00, 9'd0, 3'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 1'b0, 2'b00, 9'd0, 3'd0);

    // R3: identical codes
    runOne(24'h000000, 24'h000000, "R3 equal zero");
    runOne(24'hFFFFFF, 24'hFFFFFF, "R3 equal ones");
    for (int n = 0; n < 20; n++) begin
      base = 24'($urandom);
      runOne(base, base, "R3 equal random");
    end

    // R4: every byte/bit address, single-bit error pattern
    for (int a = 0; a < 4096; a++) begin
      ord = '0;
      for (int k = 0; k < 12; k++) begin
        ord[2*k + 1] = a[k];
        ord[2*k]     = ~a[k];
      end
      base = 24'($urandom);
      runOne(base, base ^ ordToCode(ord), "R4 correctable sweep");
    end

    // R5: single bit differences
    for (int b = 0; b < 24; b++) begin
      base = 24'($urandom);
      runOne(base, base ^ (24'h1 << b), "R5 one bit");
    end
    // R5: eleven bits (correctable pattern with one set bit removed)
    for (int a = 0; a < 48; a++) begin
      ord = '0;
      for (int k = 0; k < 12; k++) begin
        ord[2*k + 1] = a[k % 6];
        ord[2*k]     = ~a[k % 6];
      end
      pat = ord;
      for (int b = 0; b < 24; b++) if (pat[b] && (b % 4 == a % 4)) begin
        pat[b] = 1'b0;
        break;
      end
      if ($countones(pat) == 11) runOne(24'h5A5A5A, 24'h5A5A5A ^ ordToCode(pat), "R5 eleven bits");
    end

    // R6: assorted popcounts
    runOne(24'h000000, 24'h000003, "R6 two bits");
    runOne(24'h000000, 24'h001FFF, "R6 thirteen bits");
    runOne(24'h000000, 24'h7FFFFF, "R6 twenty-three bits");
    for (int n = 0; n < 400; n++) begin
      base = 24'($urandom);
      runOne(base, 24'($urandom), "R6 random pair");
    end

    // R7: erased block and its neighbours
    runOne(24'hFFFFFF, 24'h000000, "R7 erased");
    runOne(24'h000000, 24'hFFFFFF, "R7 reverse is fatal");
    runOne(24'hFFFFFF, 24'h000001, "R7 near-erased");
    runOne(24'hFFFFFF, 24'h800000, "R7 near-erased high");

    // R2: back-to-back requests, each gets its own verdict
    for (int n = 0; n < 16; n++) begin
      ord = '0;
      for (int k = 0; k < 12; k++) begin
        ord[2*k + 1] = n[k % 4];
        ord[2*k]     = ~n[k % 4];
      end
      expectOf(24'h123456, 24'h123456 ^ ordToCode(ord), stA, offA, idxA);
      expectOf(24'hFFFFFF, 24'h000000 ^ (24'(n) << 4), stB, offB, idxB);
      @(negedge clk);
      storedCode = 24'h123456; calcCode = 24'h123456 ^ ordToCode(ord); start = 1'b1;
      @(negedge clk);
      check("R2 first of pair", 1'b1, stA, offA, idxA);
      storedCode = 24'hFFFFFF; calcCode = 24'(n) << 4;
      @(negedge clk);
      start = 1'b0;
      check("R2 second of pair", 1'b1, stB, offB, idxB);
      @(negedge clk);
      check("R2 done drops", 1'b0, stB, offB, idxB);
    end

    // R1: reset mid-run returns to idle values
    @(negedge clk);
    storedCode = 24'h0; calcCode = 24'h000FFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check("R1 reset after result", 1'b0, 2'b00, 9'd0, 3'd0);
    rstN = 1'b1;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule